// File: doc/BRIEF.md
# Averaged offset calibration unit

This block derives an offset correction coefficient for a data converter and removes that offset from every conversion result it passes on. Two kinds of calibration request are accepted. A full calibration collects eight offset measurements, adds them up and keeps their rounded mean. An auto-zero collects one measurement and keeps it as it is. Whichever ran last leaves its value in a coefficient register. That register holds its value across any number of conversions and is replaced only when the next calibration completes.

Offset measurements come in over a valid/ready handshake. The block raises ready only while a calibration is collecting samples, so a measurement source can stream freely and be throttled by the block. Raw signed conversion results come in on a separate valid-qualified port. One cycle later each one leaves with the stored coefficient subtracted, clamped to the signed result range. A busy flag covers the span from an accepted request to the cycle the new coefficient takes effect.

Top module: `ofs_cal_unit`

## Requirements
- R1: After synchronous reset, busy, smp_ready and cor_valid are 0 and coef is 0.
- R2: A request on req_full or req_zero while busy is 0 is accepted; busy and smp_ready are 1 from the following cycle.
- R3: A full calibration consumes exactly eight samples (a sample is consumed on a clock edge with smp_valid and smp_ready both 1). The new coefficient is floor((S + 4) / 8), where S is the signed sum of the eight samples, so exact halves round toward positive infinity.
- R4: An auto-zero consumes exactly one sample and stores it unchanged as the coefficient.
- R5: busy returns to 0, and coef shows the new value, in the cycle after the edge that consumed the last sample of the calibration.
- R6: A request that arrives while busy is 1 is ignored: it neither restarts nor shortens the running calibration, and it does not change which kind is running.
- R7: If req_full and req_zero are both 1 in the same accepting cycle, a full calibration starts.
- R8: Each raw_valid cycle yields cor_valid one cycle later, with cor_data = raw_data - coef, using the coef held in the cycle raw_data was presented. cor_valid is 0 one cycle after a cycle without raw_valid.
- R9: The difference in R8 is clamped to the signed 13-bit limits, +4095 and -4096.
- R10: coef changes only when a calibration completes. Results presented while a calibration runs are corrected with the previous coefficient.
- R11: smp_ready is 0 whenever busy is 0. Samples offered then are not consumed and leave coef unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_full | input | 1 | Start an eight-sample averaged calibration |
| req_zero | input | 1 | Start a single-sample auto-zero |
| smp_valid | input | 1 | Offset sample present |
| smp_data | input | 13 | Signed offset sample |
| smp_ready | output | 1 | Block will take the sample on this edge |
| raw_valid | input | 1 | Raw conversion result present |
| raw_data | input | 13 | Signed raw conversion result |
| cor_valid | output | 1 | Corrected result present |
| cor_data | output | 13 | Signed corrected, saturated result |
| coef | output | 13 | Stored signed offset coefficient |
| busy | output | 1 | Calibration in progress |

## Verification
The bench drives sample sums that land exactly on a half (+4 and -4). A design that truncates, or rounds halves away from zero, stores 0 or -1 where 1 and 0 are expected. Sums at both extremes expose an accumulator that is too narrow or a rounding bias that overflows. Stray requests in the middle of a calibration catch a sequencer that restarts or switches to the single-sample path, and simultaneous requests check that the full calibration wins. Raw results pushed past either limit catch a missing or wrapped clamp. Results sent during a calibration catch a coefficient that is exposed too early.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;

    localparam int RES_W_DEF    = 13;
    localparam int AVG_LOG2_DEF = 3;

    typedef enum logic {
        ST_IDLE,
        ST_COLLECT
    } cal_state_e;

    typedef enum logic {
        CAL_ZERO,
        CAL_FULL
    } cal_kind_e;

    typedef struct packed {
        logic      go;
        cal_kind_e kind;
    } cal_req_t;

    // The full calibration takes priority when both requests coincide
    function automatic cal_req_t arbitrate(logic want_full, logic want_zero);
        cal_req_t r;
        r.go   = want_full | want_zero;
        r.kind = want_full ? CAL_FULL : CAL_ZERO;
        return r;
    endfunction

endpackage

// File: rtl/ofs_cal_seq.sv
module ofs_cal_seq
    import ofs_cal_pkg::*;
#(
    parameter int AVG_LOG2 = AVG_LOG2_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic req_full,
    input  logic req_zero,
    input  logic smp_fire,
    output logic busy,
    output logic clr_acc,
    output logic last_smp,
    output logic kind_full
);
    localparam int N_SMP = 1 << AVG_LOG2;
    localparam int CNT_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;

    cal_state_e       state;
    cal_kind_e        kind;
    logic [CNT_W-1:0] cnt;
    cal_req_t         rq;

    always_comb begin
        rq       = arbitrate(req_full, req_zero);
        clr_acc  = (state == ST_IDLE) && rq.go;
        last_smp = (state == ST_COLLECT) && smp_fire &&
                   ((kind == CAL_ZERO) || (cnt == CNT_W'(N_SMP - 1)));
        busy      = (state == ST_COLLECT);
        kind_full = (kind == CAL_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= CAL_ZERO;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rq.go) begin
                        state <= ST_COLLECT;
                        kind  <= rq.kind;
                        cnt   <= '0;
                    end
                end
                ST_COLLECT: begin
                    if (last_smp) begin
                        state <= ST_IDLE;
                    end else if (smp_fire) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ofs_cal_acc.sv
module ofs_cal_acc
    import ofs_cal_pkg::*;
#(
    parameter int RES_W    = RES_W_DEF,
    parameter int AVG_LOG2 = AVG_LOG2_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    add,
    input  logic signed [RES_W-1:0] din,
    output logic signed [RES_W-1:0] avg
);
    localparam int ACC_W = RES_W + AVG_LOG2;

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] sum_next;

    assign sum_next = acc + ACC_W'(din);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= sum_next;
        end
    end

    generate
        if (AVG_LOG2 == 0) begin : g_pass
            assign avg = RES_W'(sum_next);
        end else begin : g_round
            // One guard bit keeps the half-LSB bias from overflowing
            logic signed [ACC_W:0] biased;
            logic signed [ACC_W:0] shifted;
            assign biased  = (ACC_W + 1)'(sum_next) + (ACC_W + 1)'(1 << (AVG_LOG2 - 1));
            assign shifted = biased >>> AVG_LOG2;
            assign avg     = RES_W'(shifted);
        end
    endgenerate
endmodule

// File: rtl/ofs_cal_corr.sv
module ofs_cal_corr
    import ofs_cal_pkg::*;
#(
    parameter int RES_W = RES_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    coef_we,
    input  logic signed [RES_W-1:0] coef_wdata,
    input  logic                    raw_valid,
    input  logic signed [RES_W-1:0] raw_data,
    output logic signed [RES_W-1:0] coef,
    output logic                    cor_valid,
    output logic signed [RES_W-1:0] cor_data
);
    logic signed [RES_W:0]   diff;
    logic signed [RES_W-1:0] clamped;
    logic                    ovf;

    always_comb begin
        diff = (RES_W + 1)'(raw_data) - (RES_W + 1)'(coef);
        ovf  = diff[RES_W] ^ diff[RES_W-1];
        if (ovf) begin
            clamped = diff[RES_W] ? {1'b1, {(RES_W-1){1'b0}}}
                                  : {1'b0, {(RES_W-1){1'b1}}};
        end else begin
            clamped = diff[RES_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coef      <= '0;
            cor_valid <= 1'b0;
            cor_data  <= '0;
        end else begin
            if (coef_we) begin
                coef <= coef_wdata;
            end
            cor_valid <= raw_valid;
            if (raw_valid) begin
                cor_data <= clamped;
            end
        end
    end
endmodule

// File: rtl/ofs_cal_unit.sv
module ofs_cal_unit
    import ofs_cal_pkg::*;
#(
    parameter int RES_W    = RES_W_DEF,
    parameter int AVG_LOG2 = AVG_LOG2_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_full,
    input  logic                    req_zero,
    input  logic                    smp_valid,
    input  logic signed [RES_W-1:0] smp_data,
    output logic                    smp_ready,
    input  logic                    raw_valid,
    input  logic signed [RES_W-1:0] raw_data,
    output logic                    cor_valid,
    output logic signed [RES_W-1:0] cor_data,
    output logic signed [RES_W-1:0] coef,
    output logic                    busy
);
    logic                    smp_fire;
    logic                    clr_acc;
    logic                    last_smp;
    logic                    kind_full;
    logic signed [RES_W-1:0] avg;
    logic signed [RES_W-1:0] coef_wdata;

    assign smp_ready  = busy;
    assign smp_fire   = smp_valid & smp_ready;
    assign coef_wdata = kind_full ? avg : smp_data;

    ofs_cal_seq #(.AVG_LOG2(AVG_LOG2)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_full  (req_full),
        .req_zero  (req_zero),
        .smp_fire  (smp_fire),
        .busy      (busy),
        .clr_acc   (clr_acc),
        .last_smp  (last_smp),
        .kind_full (kind_full)
    );

    ofs_cal_acc #(.RES_W(RES_W), .AVG_LOG2(AVG_LOG2)) u_acc (
        .clk (clk),
        .rst (rst),
        .clr (clr_acc),
        .add (smp_fire),
        .din (smp_data),
        .avg (avg)
    );

    ofs_cal_corr #(.RES_W(RES_W)) u_corr (
        .clk        (clk),
        .rst        (rst),
        .coef_we    (last_smp),
        .coef_wdata (coef_wdata),
        .raw_valid  (raw_valid),
        .raw_data   (raw_data),
        .coef       (coef),
        .cor_valid  (cor_valid),
        .cor_data   (cor_data)
    );
endmodule

// File: rtl/ofs_cal_unit_chk.sv
module ofs_cal_unit_chk #(
    parameter int RES_W    = 13,
    parameter int AVG_LOG2 = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_full,
    input logic                    req_zero,
    input logic                    smp_valid,
    input logic                    smp_ready,
    input logic                    raw_valid,
    input logic                    cor_valid,
    input logic signed [RES_W-1:0] coef,
    input logic                    busy
);
    localparam int N_SMP = 1 << AVG_LOG2;

    int taken;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            taken <= 0;
        end else if (smp_valid && smp_ready) begin
            taken <= taken + 1;
        end
    end

    AST_REQ_TAKES_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!busy && (req_full || req_zero)) |=> busy) else $error("req not taken"); // R2

    AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !smp_ready) else $error("ready while idle"); // R11

    AST_COEF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(coef)) else $error("coef moved"); // R10

    AST_SAMPLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (taken == 1 || taken == N_SMP)) else $error("bad sample count"); // R3, R4

    AST_COR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        raw_valid |=> cor_valid) else $error("missing result"); // R8

    AST_COR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> !cor_valid) else $error("spurious result"); // R8
endmodule

bind ofs_cal_unit ofs_cal_unit_chk #(.RES_W(RES_W), .AVG_LOG2(AVG_LOG2)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_full  (req_full),
    .req_zero  (req_zero),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .raw_valid (raw_valid),
    .cor_valid (cor_valid),
    .coef      (coef),
    .busy      (busy)
);

// File: tb/ofs_cal_unit_test.sv
`timescale 1ns/1ps
module ofs_cal_unit_test;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_full = 1'b0;
    logic              req_zero = 1'b0;
    logic              smp_valid = 1'b0;
    logic signed [12:0] smp_data = '0;
    logic              smp_ready;
    logic              raw_valid = 1'b0;
    logic signed [12:0] raw_data = '0;
    logic              cor_valid;
    logic signed [12:0] cor_data;
    logic signed [12:0] coef;
    logic              busy;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // reference model state
    int m_busy = 0, m_full = 0, m_cnt = 0, m_acc = 0, m_coef = 0;
    int m_cv = 0, m_cd = 0;

    int sq[$];

    always #2 clk = ~clk;

    ofs_cal_unit uut (
        .clk(clk), .rst(rst), .req_full(req_full), .req_zero(req_zero),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
        .raw_valid(raw_valid), .raw_data(raw_data), .cor_valid(cor_valid),
        .cor_data(cor_data), .coef(coef), .busy(busy)
    );

    function automatic int clamp13(int v);
        if (v > 4095) return 4095;
        if (v < -4096) return -4096;
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_full = 0; m_cnt = 0; m_acc = 0; m_coef = 0;
            m_cv = 0; m_cd = 0;
        end else begin
            m_cv = raw_valid ? 1 : 0;
            if (raw_valid) m_cd = clamp13(int'(raw_data) - m_coef);
            if (m_busy == 0) begin
                if (req_full || req_zero) begin
                    m_busy = 1; m_full = req_full ? 1 : 0; m_cnt = 0; m_acc = 0;
                end
            end else if (smp_valid) begin
                m_acc += int'(smp_data);
                m_cnt++;
                if (m_full == 0) begin
                    m_coef = int'(smp_data); m_busy = 0;
                end else if (m_cnt == 8) begin
                    m_coef = (m_acc + 4) >>> 3; m_busy = 0;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            chk("R2/R5 busy", int'(busy), m_busy);
            chk("R11 smp_ready", int'(smp_ready), m_busy);
            chk(m_full != 0 ? "R3 coef" : "R4 coef", int'(coef), m_coef);
            chk("R8 cor_valid", int'(cor_valid), m_cv);
            if (m_cv != 0)
                chk((m_cd == 4095 || m_cd == -4096) ? "R9 cor_data" : "R8 cor_data",
                    int'(cor_data), m_cd);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=%0d cycles expected<50000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic request(bit f, bit z);
        @(negedge clk);
        req_full = f; req_zero = z;
        @(negedge clk);
        req_full = 1'b0; req_zero = 1'b0;
    endtask

    // feed queued samples; every gap-th cycle is left idle
    task automatic feed(int gap);
        int k = 0;
        while (sq.size() > 0) begin
            @(negedge clk);
            k++;
            if (gap > 0 && (k % gap) == 0) begin
                smp_valid = 1'b0;
            end else begin
                smp_valid = 1'b1;
                smp_data  = 13'(sq[0]);
                if (smp_ready) void'(sq.pop_front());
            end
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic full_cal(int v0, int v1, int v2, int v3, int v4, int v5, int v6, int v7, int expc, string tag);
        sq = '{v0, v1, v2, v3, v4, v5, v6, v7};
        request(1'b1, 1'b0);
        feed(3);
        chk(tag, int'(coef), expc);
        chk("R5 busy low after last sample", int'(busy), 0);
    endtask

    task automatic send_raw(int v, int expv, string tag);
        @(negedge clk);
        raw_valid = 1'b1; raw_data = 13'(v);
        @(negedge clk);
        raw_valid = 1'b0;
        chk(tag, int'(cor_data), expv);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 coef", int'(coef), 0);
        chk("R1 smp_ready", int'(smp_ready), 0);
        chk("R1 cor_valid", int'(cor_valid), 0);
        rst = 1'b0;

        send_raw(100, 100, "R8 uncalibrated");
        send_raw(-4096, -4096, "R8 uncalibrated min");

        // R11: samples while idle are not consumed
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 13'(777);
        repeat (5) @(negedge clk);
        chk("R11 ready idle", int'(smp_ready), 0);
        smp_valid = 1'b0;
        chk("R11 coef untouched", int'(coef), 0);

        full_cal(10, 12, 9, 11, 10, 13, 8, 12, 11, "R3 average");
        full_cal(1, 1, 1, 1, 0, 0, 0, 0, 1, "R3 half rounds up");
        full_cal(-1, -1, -1, -1, 0, 0, 0, 0, 0, "R3 negative half");
        full_cal(-3, -1, -2, -2, -1, -2, -1, 0, -1, "R3 negative -12");
        full_cal(4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, 4095, "R3 max sum");
        full_cal(-4096, -4096, -4096, -4096, -4096, -4096, -4096, -4096, -4096, "R3 min sum");

        // R4 auto-zero
        sq = '{-37};
        request(1'b0, 1'b1);
        feed(0);
        chk("R4 single sample", int'(coef), -37);
        send_raw(63, 100, "R8 corrected");

        // R6: stray requests mid calibration, R10: raws during busy use old coef
        sq = '{20, 20, 20, 20, 20, 20, 20, 20};
        request(1'b1, 1'b0);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 13'(20); void'(sq.pop_front());
        req_zero = 1'b1; raw_valid = 1'b1; raw_data = 13'(0);
        @(negedge clk);
        req_zero = 1'b0; raw_valid = 1'b0; smp_valid = 1'b0;
        chk("R6 still busy", int'(busy), 1);
        chk("R10 old coef used", int'(cor_data), 37);
        chk("R10 coef held", int'(coef), -37);
        request(1'b1, 1'b1);
        chk("R6 still busy after full req", int'(busy), 1);
        feed(2);
        chk("R6 eight samples averaged", int'(coef), 20);

        // R7: simultaneous requests pick full calibration
        sq = '{-5, -5, -5, -5, -5, -5, -5, -5};
        request(1'b1, 1'b1);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = 13'(-5); void'(sq.pop_front());
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R7 full wins", int'(busy), 1);
        feed(0);
        chk("R7 coef", int'(coef), -5);

        // R9 saturation both ways
        sq = '{-100};
        request(1'b0, 1'b1);
        feed(0);
        send_raw(4050, 4095, "R9 positive clamp");
        sq = '{100};
        request(1'b0, 1'b1);
        feed(0);
        send_raw(-4050, -4096, "R9 negative clamp");

        // R10 coefficient persists across many results
        for (int i = 0; i < 6; i++) send_raw(i * 500, clamp13(i * 500 - 100), "R10 persist");
        chk("R10 coef after results", int'(coef), 100);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule